// File: doc/BRIEF.md
# PRBS and Pattern Sequencer

This block produces one serial test stream. The bits come either from a small byte-wide pattern memory or from a pseudo-random binary sequence generator whose order is chosen at run time. Each bit is then line-encoded as NRZ, return-to-zero (RZ) or return-to-one (R1).

The clock runs at twice the symbol rate. Every bit therefore spans two cycles, a first half and a second half, which lets the return-to-level formats change level in the middle of a bit. Playback is started by a trigger policy: free-running, one pattern per rising edge of an external line, repeating while that line is high, or one pattern per manual pulse. A strobe marks the first half-bit of every pattern, so an instrument can lock onto the pattern boundary.

Configuration can be written at any time. It is sampled only while the block is idle or at a pattern boundary, so a pattern in flight is never corrupted.

Top module: `pattern_sequencer`

## Requirements
- R1: With `cfg_src`=1 the bit source is a Fibonacci shift register of order n in {5..15, 23, 31}. The feedback taps per order are: 5:{5,3} 6:{6,5} 7:{7,6} 8:{8,6,5,4} 9:{9,5} 10:{10,7} 11:{11,9} 12:{12,6,4,1} 13:{13,4,3,1} 14:{14,5,3,1} 15:{15,14} 23:{23,18} 31:{31,28}. The register is loaded with all ones at each pattern start and emits its oldest stage, so the first bit is 1. A pattern is 2^n-1 bits and the register never holds zero.
- R2: Any `cfg_order` value outside that set behaves exactly as order 7.
- R3: With `cfg_src`=0 a pattern is (`cfg_len`+1)*8 bits taken from the memory: byte 0 first, most significant bit of each byte first. A byte is written with `mem_we` high at `mem_addr` with `mem_wdata`.
- R4: Each bit lasts two cycles, first half then second half. Format code 0 (NRZ) drives the bit value in both halves, and code 3 behaves as NRZ.
- R5: Format code 1 (RZ): a one is high in the first half and low in the second; a zero is low throughout.
- R6: Format code 2 (R1): a zero is low in the first half and high in the second; a one is high throughout.
- R7: `ser_out_n` is always the complement of `ser_out`.
- R8: `pat_strobe` is high only during the first half of bit 0 of each pattern, for exactly one cycle.
- R9: With trigger code 0 (continuous), patterns repeat with no gap. Bit 0 appears in the cycle after the clock edge that samples a start condition.
- R10: With trigger code 1 (edge), a rising `ext_trig` seen while idle or in the last cycle of a pattern launches exactly one pattern. Edges inside a pattern are ignored, and a held-high level never relaunches.
- R11: With trigger code 2 (level), a new pattern starts at each boundary while `ext_trig` is high. When it is low, the pattern in progress completes and output halts.
- R12: With trigger code 3 (manual), a one-cycle `man_trig` pulse launches exactly one pattern.
- R13: While idle, `ser_out` is low, or high when the sampled format is R1. After reset it is low.
- R14: Changes to source, order, format or length made during a pattern take effect only from the next pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-bit clock (two cycles per bit) |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src | input | 1 | Bit source: 0 memory, 1 PRBS |
| cfg_order | input | 5 | PRBS order n |
| cfg_fmt | input | 2 | Line format: 0 NRZ, 1 RZ, 2 R1, 3 NRZ |
| cfg_trig | input | 2 | Trigger policy: 0 continuous, 1 edge, 2 level, 3 manual |
| cfg_len | input | AW | Memory pattern length in bytes minus one |
| mem_we | input | 1 | Pattern memory write enable |
| mem_addr | input | AW | Pattern memory byte address |
| mem_wdata | input | 8 | Pattern memory write data |
| ext_trig | input | 1 | External trigger line |
| man_trig | input | 1 | Manual trigger pulse |
| ser_out | output | 1 | Encoded serial data |
| ser_out_n | output | 1 | Complement of ser_out |
| pat_strobe | output | 1 | First half-bit marker of each pattern |

## Verification
A wrong tap mask or seed shows at `ser_out` within a few bits. The first n bits are always ones, and the first feedback bit emerges at bit n, so a bad polynomial is exposed within one register length. A miscounted pattern length moves `pat_strobe` and leaves idle cycles, or missing ones, at the next boundary, so it is visible at the end of the first pattern. A wrong half-bit phase or format decode corrupts the very first half-bit. Trigger-policy faults appear either one cycle after the trigger as a missing start, or at the first boundary as a wrong repeat or halt.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int LFSR_W = 31;

  typedef enum logic [1:0] {
    FMT_NRZ     = 2'd0,
    FMT_RZ      = 2'd1,
    FMT_R1      = 2'd2,
    FMT_NRZ_ALT = 2'd3
  } line_fmt_e;

  typedef enum logic [1:0] {
    TRG_CONT   = 2'd0,
    TRG_EDGE   = 2'd1,
    TRG_LEVEL  = 2'd2,
    TRG_MANUAL = 2'd3
  } trig_mode_e;

  // Map unsupported orders onto order 7.
  function automatic logic [4:0] order_fix(input logic [4:0] ord);
    if ((ord >= 5'd5 && ord <= 5'd15) || ord == 5'd23 || ord == 5'd31)
      return ord;
    return 5'd7;
  endfunction

  // Feedback stages (bit index = tap - 1) for each supported order.
  function automatic logic [LFSR_W-1:0] tap_mask(input logic [4:0] ord);
    logic [LFSR_W-1:0] m;
    m = '0;
    case (ord)
      5'd5:  begin m[4] = 1'b1; m[2] = 1'b1; end
      5'd6:  begin m[5] = 1'b1; m[4] = 1'b1; end
      5'd8:  begin m[7] = 1'b1; m[5] = 1'b1; m[4] = 1'b1; m[3] = 1'b1; end
      5'd9:  begin m[8] = 1'b1; m[4] = 1'b1; end
      5'd10: begin m[9] = 1'b1; m[6] = 1'b1; end
      5'd11: begin m[10] = 1'b1; m[8] = 1'b1; end
      5'd12: begin m[11] = 1'b1; m[5] = 1'b1; m[3] = 1'b1; m[0] = 1'b1; end
      5'd13: begin m[12] = 1'b1; m[3] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
      5'd14: begin m[13] = 1'b1; m[4] = 1'b1; m[2] = 1'b1; m[0] = 1'b1; end
      5'd15: begin m[14] = 1'b1; m[13] = 1'b1; end
      5'd23: begin m[22] = 1'b1; m[17] = 1'b1; end
      5'd31: begin m[30] = 1'b1; m[27] = 1'b1; end
      default: begin m[6] = 1'b1; m[5] = 1'b1; end
    endcase
    return m;
  endfunction

  // 2^n - 1 as a mask of the live stages.
  function automatic logic [LFSR_W-1:0] order_ones(input logic [4:0] ord);
    logic [LFSR_W-1:0] one;
    one = LFSR_W'(1);
    return (one << ord) - LFSR_W'(1);
  endfunction

  // Index of the last bit of a PRBS pattern (2^n - 2).
  function automatic logic [LFSR_W-1:0] prbs_last(input logic [4:0] ord);
    return order_ones(ord) - LFSR_W'(1);
  endfunction
endpackage

// File: rtl/sq_prbs.sv
module sq_prbs
  import sq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic [4:0]        load_order,
  input  logic [4:0]        run_order,
  output logic [LFSR_W-1:0] state,
  output logic              bit_out
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb      = ^(state_q & tap_mask(run_order));
  assign bit_out = state_q[5'(run_order - 5'd1)];
  assign state   = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      state_q <= '1;
    else if (load)
      state_q <= order_ones(load_order);
    else if (step)
      state_q <= ((state_q << 1) | LFSR_W'(fb)) & order_ones(run_order);
  end
endmodule

// File: rtl/sq_patmem.sv
module sq_patmem #(
  parameter  int BYTES = 32,
  parameter  int IW    = 31,
  localparam int AW    = $clog2(BYTES)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] bit_idx,
  output logic          bit_out
);
  logic [7:0]    mem [BYTES];
  logic [IW-4:0] byte_sel;
  logic [7:0]    rd_byte;

  always_ff @(posedge clk) begin
    if (we && 32'(waddr) < BYTES)
      mem[waddr] <= wdata;
  end

  assign byte_sel = bit_idx[IW-1:3];

  always_comb begin
    if (byte_sel < (IW-3)'(BYTES))
      rd_byte = mem[byte_sel[AW-1:0]];
    else
      rd_byte = 8'h00;
  end

  // Most significant bit of each byte goes out first.
  assign bit_out = rd_byte[3'd7 - bit_idx[2:0]];
endmodule

// File: rtl/sq_lineenc.sv
module sq_lineenc
  import sq_pkg::*;
(
  input  logic      active,
  input  logic      data,
  input  logic      half,
  input  line_fmt_e fmt,
  output logic      level
);
  always_comb begin
    if (!active)
      level = (fmt == FMT_R1);
    else begin
      case (fmt)
        FMT_RZ:  level = data & ~half;
        FMT_R1:  level = data | half;
        default: level = data;
      endcase
    end
  end
endmodule

// File: rtl/pattern_sequencer.sv
module pattern_sequencer
  import sq_pkg::*;
#(
  parameter  int MEM_BYTES = 32,
  localparam int AW        = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_src,
  input  logic [4:0]    cfg_order,
  input  logic [1:0]    cfg_fmt,
  input  logic [1:0]    cfg_trig,
  input  logic [AW-1:0] cfg_len,
  input  logic          mem_we,
  input  logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_wdata,
  input  logic          ext_trig,
  input  logic          man_trig,
  output logic          ser_out,
  output logic          ser_out_n,
  output logic          pat_strobe
);
  localparam int IW = LFSR_W;

  logic          run_q, phase_q, ext_q;
  logic [IW-1:0] idx_q;
  logic          act_src;
  line_fmt_e     act_fmt;
  logic [4:0]    act_order;
  logic [AW-1:0] act_len;

  // Named events shared with the checker.
  logic          edge_hit, go, at_end, boundary, pat_start, adv_bit;
  logic [IW-1:0] last_idx;
  logic [4:0]    live_order;
  logic [IW-1:0] lfsr_state;
  logic          prbs_bit, mem_bit, cur_bit, line_bit;

  assign live_order = order_fix(cfg_order);
  assign edge_hit   = ext_trig & ~ext_q;

  always_comb begin
    case (trig_mode_e'(cfg_trig))
      TRG_CONT:  go = 1'b1;
      TRG_EDGE:  go = edge_hit;
      TRG_LEVEL: go = ext_trig;
      default:   go = man_trig;
    endcase
  end

  assign last_idx  = act_src ? prbs_last(act_order) : IW'({act_len, 3'b111});
  assign at_end    = run_q & phase_q & (idx_q == last_idx);
  assign boundary  = ~run_q | at_end;
  assign pat_start = boundary & go;
  assign adv_bit   = run_q & phase_q & ~at_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      phase_q   <= 1'b0;
      idx_q     <= '0;
      ext_q     <= 1'b0;
      act_src   <= 1'b0;
      act_fmt   <= FMT_NRZ;
      act_order <= 5'd7;
      act_len   <= '0;
    end else begin
      ext_q <= ext_trig;
      if (boundary) begin
        act_src   <= cfg_src;
        act_fmt   <= line_fmt_e'(cfg_fmt);
        act_order <= live_order;
        act_len   <= cfg_len;
        run_q     <= pat_start;
        phase_q   <= 1'b0;
        idx_q     <= '0;
      end else begin
        phase_q <= ~phase_q;
        if (phase_q)
          idx_q <= idx_q + IW'(1);
      end
    end
  end

  sq_prbs u_prbs (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (boundary),
    .step       (adv_bit),
    .load_order (live_order),
    .run_order  (act_order),
    .state      (lfsr_state),
    .bit_out    (prbs_bit)
  );

  sq_patmem #(.BYTES(MEM_BYTES), .IW(IW)) u_mem (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_addr),
    .wdata   (mem_wdata),
    .bit_idx (idx_q),
    .bit_out (mem_bit)
  );

  assign cur_bit = act_src ? prbs_bit : mem_bit;

  sq_lineenc u_enc (
    .active (run_q),
    .data   (cur_bit),
    .half   (phase_q),
    .fmt    (act_fmt),
    .level  (line_bit)
  );

  assign ser_out    = line_bit;
  assign ser_out_n  = ~line_bit;
  assign pat_strobe = run_q & ~phase_q & (idx_q == '0);
endmodule

// File: rtl/sq_checker.sv
module sq_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        run_q,
  input logic        phase_q,
  input logic        at_end,
  input logic [1:0]  act_fmt,
  input logic [4:0]  act_order,
  input logic        act_src,
  input logic [30:0] lfsr_state,
  input logic [1:0]  cfg_trig,
  input logic        ext_trig,
  input logic        ser_out,
  input logic        pat_strobe
);
  // R8
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_strobe |=> !pat_strobe);

  // R8
  strobe_first_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pat_strobe |-> (run_q && !phase_q));

  // R4
  half_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(at_end)) |-> (phase_q != $past(phase_q)));

  // R1
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_state != 31'd0);

  // R14
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q) && !$past(at_end)) |->
      ($stable(act_order) && $stable(act_fmt) && $stable(act_src)));

  // R5
  rz_second_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && act_fmt == 2'd1 && phase_q) |-> !ser_out);

  // R13
  idle_r1_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && act_fmt == 2'd2) |-> ser_out);

  // R11
  level_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(at_end) && !$past(ext_trig) && $past(cfg_trig) == 2'd2) |-> !run_q);
endmodule

bind pattern_sequencer sq_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .run_q      (run_q),
  .phase_q    (phase_q),
  .at_end     (at_end),
  .act_fmt    (act_fmt),
  .act_order  (act_order),
  .act_src    (act_src),
  .lfsr_state (lfsr_state),
  .cfg_trig   (cfg_trig),
  .ext_trig   (ext_trig),
  .ser_out    (ser_out),
  .pat_strobe (pat_strobe)
);

// File: tb/test_pattern_sequencer.sv
module test_pattern_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_BYTES  = 32;
  localparam int AW         = $clog2(MEM_BYTES);

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cfg_src;
  logic [4:0]    cfg_order;
  logic [1:0]    cfg_fmt, cfg_trig;
  logic [AW-1:0] cfg_len;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic          ext_trig, man_trig;
  logic          ser_out, ser_out_n, pat_strobe;

  typedef struct {
    logic  lvl;
    logic  stb;
    string tag;
  } exp_t;
  typedef bit bitq_t[$];

  exp_t  sb[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bitq_t mem_bits;

  always #(CLK_PERIOD/2) clk = ~clk;

  pattern_sequencer #(.MEM_BYTES(MEM_BYTES)) i_pattern_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_src(cfg_src), .cfg_order(cfg_order),
    .cfg_fmt(cfg_fmt), .cfg_trig(cfg_trig), .cfg_len(cfg_len),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ext_trig(ext_trig), .man_trig(man_trig),
    .ser_out(ser_out), .ser_out_n(ser_out_n), .pat_strobe(pat_strobe)
  );

  // Bench model of the shift register: stage k holds the bit k-1 shifts old.
  function automatic bitq_t prbs_model(input int n, input int cnt);
    bitq_t res;
    bit st[32];
    int t1, t2, t3, t4;
    bit fb;
    t3 = 0; t4 = 0;
    case (n)
      5: begin t1 = 5; t2 = 3; end
      6: begin t1 = 6; t2 = 5; end
      7: begin t1 = 7; t2 = 6; end
      23: begin t1 = 23; t2 = 18; end
      31: begin t1 = 31; t2 = 28; end
      default: begin t1 = 7; t2 = 6; end
    endcase
    for (int k = 0; k < 32; k++) st[k] = (k >= 1 && k <= n);
    for (int i = 0; i < cnt; i++) begin
      res.push_back(st[n]);
      fb = st[t1] ^ st[t2] ^ (t3 != 0 && st[t3]) ^ (t4 != 0 && st[t4]);
      for (int k = n; k >= 2; k--) st[k] = st[k-1];
      st[1] = fb;
    end
    return res;
  endfunction

  task automatic push_pat(input bitq_t bits, input int fmt, input string tag);
    for (int i = 0; i < bits.size(); i++) begin
      for (int h = 0; h < 2; h++) begin
        exp_t e;
        case (fmt)
          1: e.lvl = (h == 0) ? bits[i] : 1'b0;   // RZ
          2: e.lvl = (h == 1) ? 1'b1 : bits[i];   // R1
          default: e.lvl = bits[i];              // NRZ
        endcase
        e.stb = (i == 0 && h == 0);
        e.tag = tag;
        sb.push_back(e);
      end
    end
  endtask

  task automatic push_idle(input int n, input logic lvl, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.lvl = lvl; e.stb = 1'b0; e.tag = tag;
      sb.push_back(e);
    end
  endtask

  task automatic drain();
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_now(input logic lvl, input string tag);
    n_chk++;
    if (ser_out !== lvl || ser_out_n !== ~lvl || pat_strobe !== 1'b0) begin
      n_bad++;
      $display("FAIL %s: out=%b out_n=%b strobe=%b expected %b/%b/0",
               tag, ser_out, ser_out_n, pat_strobe, lvl, ~lvl);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // Monitor: compare each produced half-bit with the scoreboard head.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++;
        if (ser_out !== e.lvl || ser_out_n !== ~e.lvl || pat_strobe !== e.stb) begin
          n_bad++;
          $display("FAIL %s (R7/R8): out=%b out_n=%b strobe=%b expected %b/%b/%b",
                   e.tag, ser_out, ser_out_n, pat_strobe, e.lvl, ~e.lvl, e.stb);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [7:0] img [2];
    img[0] = 8'hA5; img[1] = 8'h3C;
    for (int b = 0; b < 2; b++)
      for (int k = 7; k >= 0; k--) mem_bits.push_back(img[b][k]);

    rst_n = 1'b0; cfg_src = 1'b0; cfg_order = 5'd5; cfg_fmt = 2'd0;
    cfg_trig = 2'd3; cfg_len = '0; mem_we = 1'b0; mem_addr = '0;
    mem_wdata = '0; ext_trig = 1'b0; man_trig = 1'b0;
    do_reset();
    check_now(1'b0, "R13 reset idle");

    for (int b = 0; b < 2; b++) begin
      mem_we = 1'b1; mem_addr = AW'(b); mem_wdata = img[b];
      @(negedge clk);
    end
    mem_we = 1'b0;
    cfg_len = AW'(1);
    @(negedge clk);

    // R3 R4 R12: memory pattern, NRZ, one manual pulse
    man_trig = 1'b1;
    push_pat(mem_bits, 0, "R3 R12 nrz manual");
    push_idle(6, 1'b0, "R12 R13 idle after one-shot");
    @(negedge clk);
    man_trig = 1'b0;
    drain();

    // R5 R10: RZ, edge trigger, second edge inside the pattern ignored
    cfg_fmt = 2'd1; cfg_trig = 2'd1;
    @(negedge clk);
    ext_trig = 1'b1;
    push_pat(mem_bits, 1, "R5 R10 rz edge");
    push_idle(6, 1'b0, "R10 held high no relaunch");
    repeat (5) @(negedge clk);
    ext_trig = 1'b0;
    repeat (2) @(negedge clk);
    ext_trig = 1'b1;
    drain();
    ext_trig = 1'b0;

    // R6 R11 R13: R1, level mode, drop inside the second pattern
    cfg_fmt = 2'd2; cfg_trig = 2'd2;
    @(negedge clk);
    @(negedge clk);
    check_now(1'b1, "R13 idle high in R1");
    ext_trig = 1'b1;
    push_pat(mem_bits, 2, "R6 R11 r1 level first");
    push_pat(mem_bits, 2, "R11 r1 level repeat");
    push_idle(6, 1'b1, "R11 R13 halt idles high");
    repeat (37) @(negedge clk);
    ext_trig = 1'b0;
    drain();

    // R4 R9 R14: code 3 as NRZ, continuous; length and format change deferred
    cfg_fmt = 2'd3; cfg_trig = 2'd0; cfg_len = AW'(1);
    begin
      bitq_t first8;
      for (int i = 0; i < 8; i++) first8.push_back(mem_bits[i]);
      push_pat(mem_bits, 0, "R4 R9 code3 nrz continuous");
      push_pat(first8, 1, "R14 deferred len/fmt");
    end
    push_idle(6, 1'b0, "R14 idle after stop");
    repeat (3) @(negedge clk);
    cfg_len = '0; cfg_fmt = 2'd1;
    repeat (32) @(negedge clk);
    cfg_trig = 2'd3;
    drain();

    // R1 R9 R14: PRBS order 5 then deferred change to order 6
    cfg_src = 1'b1; cfg_order = 5'd5; cfg_fmt = 2'd0; cfg_trig = 2'd0;
    push_pat(prbs_model(5, 31), 0, "R1 R9 prbs5 continuous");
    push_pat(prbs_model(6, 63), 0, "R1 R14 prbs6 after boundary");
    push_idle(6, 1'b0, "R1 length end");
    repeat (3) @(negedge clk);
    cfg_order = 5'd6;
    repeat (62) @(negedge clk);
    cfg_trig = 2'd3;
    drain();

    // R2: unsupported order acts as order 7
    cfg_order = 5'd0;
    @(negedge clk);
    man_trig = 1'b1;
    push_pat(prbs_model(7, 127), 0, "R2 order0 as 7");
    push_idle(4, 1'b0, "R2 length 127");
    @(negedge clk);
    man_trig = 1'b0;
    drain();

    // R1: long orders, prefix only, then reset
    cfg_order = 5'd23;
    @(negedge clk);
    man_trig = 1'b1;
    push_pat(prbs_model(23, 120), 0, "R1 prbs23 prefix");
    @(negedge clk);
    man_trig = 1'b0;
    drain();
    do_reset();
    check_now(1'b0, "R13 reset stops pattern");

    cfg_order = 5'd31;
    @(negedge clk);
    man_trig = 1'b1;
    push_pat(prbs_model(31, 120), 0, "R1 prbs31 prefix");
    @(negedge clk);
    man_trig = 1'b0;
    drain();
    do_reset();

    finish_run();
  end
endmodule